// File: doc/BRIEF.md
# Character Display Instruction Executor

This block sits behind the bus front end of a two-line, forty-column character display. Each transfer reaches it as one byte plus two flags. The register-select flag separates commands and status from data. The write and read strobes give the direction. The block decodes the command byte and keeps the address counter and the flag that selects the character-generator space or the display-data space. It also keeps the entry mode, the display on/cursor/blink controls, the bus-width bit, the horizontal display offset, the brightness code and the busy flag. It owns a 128 x 8 display-data store and a 64 x 8 glyph store, and it performs the reads and writes into them.

A host writes commands and data, then watches the status byte until the busy bit drops. A clear command, and reset, start a sweep that writes the blank code into every display-data location, one location per cycle. Busy stays high for a longer window while the sweep runs. The display scanner takes the control outputs and the offset from the block.

Top module: `chardisp_exec`

## Requirements
- R1: A command byte is decoded by its highest set bit: bit0 = clear, bit1 = home, bit2 = entry mode (bit1 = up/down, bit0 = shift on write), bit3 = display control, bit4 = cursor/display move (bit3 = move display, bit2 = right), bit5 = function set, bit6 = glyph address (low 6 bits), bit7 = display address (low 7 bits). Command 00h changes nothing.
- R2: Reset and the clear command write 20h into all 128 display-data locations. They set the counter to 0 in display space, set the offset to 0 and select up-counting, and the shift-on-write bit keeps its value. Busy is then high for exactly CLEAR_CYCLES cycles. Reset also turns the display, cursor and blink off, sets wide bus mode and sets brightness code 0.
- R3: Every accepted write or data read holds busy high for exactly CMD_CYCLES cycles. Writes and data reads that arrive while busy is high are ignored. Status reads are always served.
- R4: In display space the counter steps by one after each data access. Going up it runs 27h to 40h and 67h to 00h. Going down it runs 40h to 27h and 00h to 67h.
- R5: In glyph space the counter is 6 bits wide and wraps between 3Fh and 00h in both directions. Glyph writes leave the display-data store untouched.
- R6: With shift-on-write set, a display-data write moves the offset one column opposite to the counting direction, and the counter still steps. A left move adds 1 to the offset modulo LINE_LEN; a right move subtracts 1 modulo LINE_LEN. Display reads and glyph accesses never move the offset.
- R7: The move command with bit3 = 0 steps only the counter, up for right and down for left. With bit3 = 1 it moves only the offset, and the offset wraps modulo LINE_LEN.
- R8: Home sets the counter to 0 in display space and the offset to 0, and leaves stored data unchanged.
- R9: When a data write is the next accepted write after a function set, that write loads brightness from bits [1:0] and does not touch any store or the counter. Any command write in between cancels the capture.
- R10: statusOut carries busy in bit 7 and the counter in bits 6:0. A status read (read with register-select 0) returns that byte in rdData one cycle later.
- R11: Display control loads displayOn, cursorOn and blinkOn from bits 2, 1 and 0. Function set loads busWide from bit 4.
- R12: A data read returns the addressed byte of the selected store in rdData, with rdValid high, one cycle after the strobe. The counter then steps as in R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per transfer |
| rdEn | input | 1 | Read strobe, one cycle per transfer |
| regSel | input | 1 | 0 = command/status, 1 = data |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read result |
| rdValid | output | 1 | rdData updated this cycle |
| statusOut | output | 8 | Busy bit and address counter |
| displayOn | output | 1 | Display enable |
| cursorOn | output | 1 | Cursor enable |
| blinkOn | output | 1 | Blink enable |
| busWide | output | 1 | 1 = 8-bit host bus |
| brightness | output | 2 | Brightness code, 0 = full |
| shiftOfs | output | $clog2(LINE_LEN) | Display offset, 0 to LINE_LEN-1 |

## Verification
The bench builds the block with its defaults: LINE_LEN = 40, CMD_CYCLES = 3 and CLEAR_CYCLES = 150. With a 40-column line, both line-end wraps at 27h and 67h can be reached with a few writes, and the offset wrap between 0 and 39 can be reached the same way. A 150-cycle clear window covers the full 128-location blank sweep, and it is long enough to send commands, data and status reads into it. The exact busy lengths of 3 and 150 cycles are counted at the status port.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  localparam int DATA_W   = 8;
  localparam int AC_W     = 7;
  localparam int CG_AW    = 6;
  localparam int DD_DEPTH = 2 ** AC_W;
  localparam int CG_DEPTH = 2 ** CG_AW;

  localparam logic [DATA_W-1:0] BLANK_CODE = 8'h20;
  localparam logic [AC_W-1:0]   LINE2_BASE = 7'h40;

  typedef enum logic [3:0] {
    CK_NONE, CK_CLEAR, CK_HOME, CK_ENTRY, CK_DISP,
    CK_MOVE, CK_FUNC, CK_CGADR, CK_DDADR
  } cmdKind_t;

  typedef struct packed {
    logic              loadAc;
    logic [AC_W-1:0]   acVal;
    logic              selCg;
    logic              selDd;
    logic              stepAc;
    logic              stepUp;
    logic              shiftDisp;
    logic              shiftLeft;
    logic              zeroShift;
    logic              ddWrite;
    logic              cgWrite;
    logic              ramRead;
    logic              statusRead;
    logic              setEntry;
    logic              setDisp;
    logic              setFunc;
    logic              setBrt;
    logic              forceInc;
    logic              fillEn;
    logic [AC_W-1:0]   fillAddr;
    logic [DATA_W-1:0] payload;
  } ctlStrobes_t;

endpackage

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int CMD_CYCLES   = 3,
  parameter int CLEAR_CYCLES = 150
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              incMode,
  input  logic              entryShift,
  input  logic              cgSel,
  output ctlStrobes_t       ctl,
  output logic              busy
);

  localparam int CNT_W = $clog2(CLEAR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CLR_LOAD = CNT_W'(CLEAR_CYCLES);
  localparam logic [CNT_W-1:0] CMD_LOAD = CNT_W'(CMD_CYCLES);
  localparam logic [AC_W-1:0]  FILL_LAST = AC_W'(DD_DEPTH - 1);

  logic [CNT_W-1:0] busyCnt;
  logic             fillOn;
  logic [AC_W-1:0]  fillPtr;
  logic             brtArm;
  logic             wrAcc;
  logic             rdAcc;
  logic             stRd;
  logic             startClear;
  cmdKind_t         kind;

  function automatic cmdKind_t decodeCmd(input logic [DATA_W-1:0] b);
    casez (b)
      8'b1???????: return CK_DDADR;
      8'b01??????: return CK_CGADR;
      8'b001?????: return CK_FUNC;
      8'b0001????: return CK_MOVE;
      8'b00001???: return CK_DISP;
      8'b000001??: return CK_ENTRY;
      8'b0000001?: return CK_HOME;
      8'b00000001: return CK_CLEAR;
      default:     return CK_NONE;
    endcase
  endfunction

  assign busy  = (busyCnt != '0);
  assign wrAcc = wrEn & ~busy;
  assign rdAcc = rdEn & ~wrEn & regSel & ~busy;
  assign stRd  = rdEn & ~wrEn & ~regSel;
  assign kind  = decodeCmd(wrData);

  always_comb begin
    ctl          = '0;
    ctl.payload  = wrData;
    ctl.stepUp   = incMode;
    ctl.fillEn   = fillOn;
    ctl.fillAddr = fillPtr;
    startClear   = 1'b0;
    if (wrAcc && regSel) begin
      if (brtArm) begin
        ctl.setBrt = 1'b1;
      end else if (cgSel) begin
        ctl.cgWrite = 1'b1;
        ctl.stepAc  = 1'b1;
      end else begin
        ctl.ddWrite   = 1'b1;
        ctl.stepAc    = 1'b1;
        ctl.shiftDisp = entryShift;
        ctl.shiftLeft = incMode;
      end
    end else if (wrAcc) begin
      case (kind)
        CK_CLEAR: begin
          startClear    = 1'b1;
          ctl.loadAc    = 1'b1;
          ctl.selDd     = 1'b1;
          ctl.zeroShift = 1'b1;
          ctl.forceInc  = 1'b1;
        end
        CK_HOME: begin
          ctl.loadAc    = 1'b1;
          ctl.selDd     = 1'b1;
          ctl.zeroShift = 1'b1;
        end
        CK_ENTRY: ctl.setEntry = 1'b1;
        CK_DISP:  ctl.setDisp  = 1'b1;
        CK_MOVE: begin
          if (wrData[3]) begin
            ctl.shiftDisp = 1'b1;
            ctl.shiftLeft = ~wrData[2];
          end else begin
            ctl.stepAc = 1'b1;
            ctl.stepUp = wrData[2];
          end
        end
        CK_FUNC: ctl.setFunc = 1'b1;
        CK_CGADR: begin
          ctl.loadAc = 1'b1;
          ctl.acVal  = {1'b0, wrData[CG_AW-1:0]};
          ctl.selCg  = 1'b1;
        end
        CK_DDADR: begin
          ctl.loadAc = 1'b1;
          ctl.acVal  = wrData[AC_W-1:0];
          ctl.selDd  = 1'b1;
        end
        default: ;
      endcase
    end else if (rdAcc) begin
      ctl.ramRead = 1'b1;
      ctl.stepAc  = 1'b1;
    end
    if (stRd) ctl.statusRead = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= CLR_LOAD;
    end else if (startClear) begin
      busyCnt <= CLR_LOAD;
    end else if (wrAcc || rdAcc) begin
      busyCnt <= CMD_LOAD;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillOn  <= 1'b1;
      fillPtr <= '0;
    end else if (startClear) begin
      fillOn  <= 1'b1;
      fillPtr <= '0;
    end else if (fillOn) begin
      if (fillPtr == FILL_LAST) fillOn <= 1'b0;
      fillPtr <= fillPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brtArm <= 1'b0;
    end else if (wrAcc) begin
      brtArm <= ~regSel && (kind == CK_FUNC);
    end
  end

  AST_FILL_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    fillOn |-> busy); // R2

  AST_ONE_STORE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ddWrite, ctl.cgWrite, ctl.setBrt, ctl.ramRead})); // R9

endmodule

// File: rtl/chardisp_dpath.sv
module chardisp_dpath
  import chardisp_pkg::*;
#(
  parameter int LINE_LEN = 40,
  localparam int SH_W    = $clog2(LINE_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              busy,
  output logic [AC_W-1:0]   acQ,
  output logic              cgSel,
  output logic              incMode,
  output logic              entryShift,
  output logic              displayOn,
  output logic              cursorOn,
  output logic              blinkOn,
  output logic              busWide,
  output logic [1:0]        brtQ,
  output logic [SH_W-1:0]   shiftQ,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam logic [AC_W-1:0] LINE1_LAST = AC_W'(LINE_LEN - 1);
  localparam logic [AC_W-1:0] LINE2_LAST = LINE2_BASE + LINE1_LAST;
  localparam logic [SH_W-1:0] SH_LAST    = SH_W'(LINE_LEN - 1);

  logic [DATA_W-1:0] ddRam [DD_DEPTH];
  logic [DATA_W-1:0] cgRam [CG_DEPTH];

  function automatic logic [AC_W-1:0] nextAc(input logic [AC_W-1:0] a,
                                             input logic up, input logic cg);
    logic [CG_AW-1:0] c;
    if (cg) begin
      c = up ? a[CG_AW-1:0] + 1'b1 : a[CG_AW-1:0] - 1'b1;
      return {1'b0, c};
    end
    if (up) begin
      if (a == LINE1_LAST) return LINE2_BASE;
      if (a == LINE2_LAST) return '0;
      return a + 1'b1;
    end
    if (a == '0)         return LINE2_LAST;
    if (a == LINE2_BASE) return LINE1_LAST;
    return a - 1'b1;
  endfunction

  function automatic logic [SH_W-1:0] nextShift(input logic [SH_W-1:0] s,
                                                input logic left);
    if (left) return (s == SH_LAST) ? '0 : s + 1'b1;
    return (s == '0) ? SH_LAST : s - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acQ   <= '0;
      cgSel <= 1'b0;
    end else begin
      if (ctl.loadAc)      acQ <= ctl.acVal;
      else if (ctl.stepAc) acQ <= nextAc(acQ, ctl.stepUp, cgSel);
      if (ctl.selCg)       cgSel <= 1'b1;
      else if (ctl.selDd)  cgSel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (ctl.zeroShift) begin
      shiftQ <= '0;
    end else if (ctl.shiftDisp) begin
      shiftQ <= nextShift(shiftQ, ctl.shiftLeft);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incMode    <= 1'b1;
      entryShift <= 1'b0;
      displayOn  <= 1'b0;
      cursorOn   <= 1'b0;
      blinkOn    <= 1'b0;
      busWide    <= 1'b1;
      brtQ       <= 2'b00;
    end else begin
      if (ctl.setEntry) begin
        incMode    <= ctl.payload[1];
        entryShift <= ctl.payload[0];
      end else if (ctl.forceInc) begin
        incMode <= 1'b1;
      end
      if (ctl.setDisp) begin
        displayOn <= ctl.payload[2];
        cursorOn  <= ctl.payload[1];
        blinkOn   <= ctl.payload[0];
      end
      if (ctl.setFunc) busWide <= ctl.payload[4];
      if (ctl.setBrt)  brtQ    <= ctl.payload[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillEn)       ddRam[ctl.fillAddr] <= BLANK_CODE;
    else if (ctl.ddWrite) ddRam[acQ]          <= ctl.payload;
    if (ctl.cgWrite)      cgRam[acQ[CG_AW-1:0]] <= ctl.payload;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.ramRead | ctl.statusRead;
      if (ctl.ramRead)
        rdData <= cgSel ? cgRam[acQ[CG_AW-1:0]] : ddRam[acQ];
      else if (ctl.statusRead)
        rdData <= {busy, acQ};
    end
  end

  AST_AC_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(acQ)); // R3

  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    shiftQ <= SH_LAST); // R7

  AST_CG_AC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cgSel |-> (acQ[AC_W-1] == 1'b0)); // R5

  AST_BRT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(brtQ) |-> $past(ctl.setBrt)); // R9

endmodule

// File: rtl/chardisp_exec.sv
module chardisp_exec
  import chardisp_pkg::*;
#(
  parameter int LINE_LEN     = 40,
  parameter int CMD_CYCLES   = 3,
  parameter int CLEAR_CYCLES = 150
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic                        regSel,
  input  logic [7:0]                  wrData,
  output logic [7:0]                  rdData,
  output logic                        rdValid,
  output logic [7:0]                  statusOut,
  output logic                        displayOn,
  output logic                        cursorOn,
  output logic                        blinkOn,
  output logic                        busWide,
  output logic [1:0]                  brightness,
  output logic [$clog2(LINE_LEN)-1:0] shiftOfs
);

  ctlStrobes_t     ctl;
  logic            busy;
  logic [AC_W-1:0] acQ;
  logic            cgSel;
  logic            incMode;
  logic            entryShift;

  chardisp_ctrl #(
    .CMD_CYCLES  (CMD_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .regSel    (regSel),
    .wrData    (wrData),
    .incMode   (incMode),
    .entryShift(entryShift),
    .cgSel     (cgSel),
    .ctl       (ctl),
    .busy      (busy)
  );

  chardisp_dpath #(
    .LINE_LEN(LINE_LEN)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busy      (busy),
    .acQ       (acQ),
    .cgSel     (cgSel),
    .incMode   (incMode),
    .entryShift(entryShift),
    .displayOn (displayOn),
    .cursorOn  (cursorOn),
    .blinkOn   (blinkOn),
    .busWide   (busWide),
    .brtQ      (brightness),
    .shiftQ    (shiftOfs),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

  assign statusOut = {busy, acQ};

endmodule

// File: tb/chardisp_exec_tb_top.sv
module chardisp_exec_tb_top;

  localparam int LINE_LEN     = 40;
  localparam int CMD_CYCLES   = 3;
  localparam int CLEAR_CYCLES = 150;
  localparam int SH_W         = $clog2(LINE_LEN);

  localparam logic [1:0] KC = 2'd0;  // command write
  localparam logic [1:0] KW = 2'd1;  // data write
  localparam logic [1:0] KR = 2'd2;  // data read

  // {kind, byte, expected counter, expected offset, expected read byte}
  localparam int NV = 62;
  localparam logic [30:0] VEC [NV] = '{
    {KC, 8'h80, 7'h00, 6'd0,  8'h00},
    {KW, 8'h41, 7'h01, 6'd0,  8'h00},
    {KW, 8'h42, 7'h02, 6'd0,  8'h00},
    {KC, 8'h80, 7'h00, 6'd0,  8'h00},
    {KR, 8'h00, 7'h01, 6'd0,  8'h41},
    {KR, 8'h00, 7'h02, 6'd0,  8'h42},
    {KR, 8'h00, 7'h03, 6'd0,  8'h20},
    {KC, 8'hA7, 7'h27, 6'd0,  8'h00},
    {KW, 8'h5A, 7'h40, 6'd0,  8'h00},
    {KC, 8'h04, 7'h40, 6'd0,  8'h00},
    {KW, 8'h59, 7'h27, 6'd0,  8'h00},
    {KC, 8'h06, 7'h27, 6'd0,  8'h00},
    {KC, 8'hE7, 7'h67, 6'd0,  8'h00},
    {KW, 8'h33, 7'h00, 6'd0,  8'h00},
    {KC, 8'hE7, 7'h67, 6'd0,  8'h00},
    {KR, 8'h00, 7'h00, 6'd0,  8'h33},
    {KC, 8'hC0, 7'h40, 6'd0,  8'h00},
    {KR, 8'h00, 7'h41, 6'd0,  8'h59},
    {KC, 8'h7F, 7'h3F, 6'd0,  8'h00},
    {KW, 8'h1F, 7'h00, 6'd0,  8'h00},
    {KC, 8'h7F, 7'h3F, 6'd0,  8'h00},
    {KR, 8'h00, 7'h00, 6'd0,  8'h1F},
    {KC, 8'h04, 7'h00, 6'd0,  8'h00},
    {KC, 8'h40, 7'h00, 6'd0,  8'h00},
    {KW, 8'h15, 7'h3F, 6'd0,  8'h00},
    {KC, 8'h06, 7'h3F, 6'd0,  8'h00},
    {KC, 8'h40, 7'h00, 6'd0,  8'h00},
    {KR, 8'h00, 7'h01, 6'd0,  8'h15},
    {KC, 8'hA7, 7'h27, 6'd0,  8'h00},
    {KR, 8'h00, 7'h40, 6'd0,  8'h5A},
    {KC, 8'h85, 7'h05, 6'd0,  8'h00},
    {KC, 8'h14, 7'h06, 6'd0,  8'h00},
    {KC, 8'h10, 7'h05, 6'd0,  8'h00},
    {KC, 8'h18, 7'h05, 6'd1,  8'h00},
    {KC, 8'h1C, 7'h05, 6'd0,  8'h00},
    {KC, 8'h1C, 7'h05, 6'd39, 8'h00},
    {KC, 8'h18, 7'h05, 6'd0,  8'h00},
    {KC, 8'h07, 7'h05, 6'd0,  8'h00},
    {KC, 8'h80, 7'h00, 6'd0,  8'h00},
    {KW, 8'h61, 7'h01, 6'd1,  8'h00},
    {KC, 8'h80, 7'h00, 6'd1,  8'h00},
    {KR, 8'h00, 7'h01, 6'd1,  8'h61},
    {KC, 8'h05, 7'h01, 6'd1,  8'h00},
    {KW, 8'h62, 7'h00, 6'd0,  8'h00},
    {KW, 8'h63, 7'h67, 6'd39, 8'h00},
    {KC, 8'h07, 7'h67, 6'd39, 8'h00},
    {KC, 8'h40, 7'h00, 6'd39, 8'h00},
    {KW, 8'h00, 7'h01, 6'd39, 8'h00},
    {KC, 8'h06, 7'h01, 6'd39, 8'h00},
    {KC, 8'h02, 7'h00, 6'd0,  8'h00},
    {KC, 8'h80, 7'h00, 6'd0,  8'h00},
    {KR, 8'h00, 7'h01, 6'd0,  8'h63},
    {KC, 8'h30, 7'h01, 6'd0,  8'h00},
    {KW, 8'h02, 7'h01, 6'd0,  8'h00},
    {KC, 8'h20, 7'h01, 6'd0,  8'h00},
    {KC, 8'h81, 7'h01, 6'd0,  8'h00},
    {KW, 8'h03, 7'h02, 6'd0,  8'h00},
    {KC, 8'h81, 7'h01, 6'd0,  8'h00},
    {KR, 8'h00, 7'h02, 6'd0,  8'h03},
    {KC, 8'h80, 7'h00, 6'd0,  8'h00},
    {KR, 8'h00, 7'h01, 6'd0,  8'h63},
    {KC, 8'h00, 7'h01, 6'd0,  8'h00}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic            rdEn = 1'b0;
  logic            regSel = 1'b0;
  logic [7:0]      wrData = '0;
  logic [7:0]      rdData;
  logic            rdValid;
  logic [7:0]      statusOut;
  logic            displayOn;
  logic            cursorOn;
  logic            blinkOn;
  logic            busWide;
  logic [1:0]      brightness;
  logic [SH_W-1:0] shiftOfs;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;
  logic [7:0] rdSample;
  logic       vldSample;

  always #2 clk = ~clk;

  chardisp_exec #(
    .LINE_LEN    (LINE_LEN),
    .CMD_CYCLES  (CMD_CYCLES),
    .CLEAR_CYCLES(CLEAR_CYCLES)
  ) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .regSel    (regSel),
    .wrData    (wrData),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .statusOut (statusOut),
    .displayOn (displayOn),
    .cursorOn  (cursorOn),
    .blinkOn   (blinkOn),
    .busWide   (busWide),
    .brightness(brightness),
    .shiftOfs  (shiftOfs)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic rs, input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1; regSel = rs; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic rs);
    @(negedge clk);
    rdEn = 1'b1; regSel = rs;
    @(negedge clk);
    rdSample  = rdData;
    vldSample = rdValid;
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (statusOut[7]) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check(statusOut == 8'h80, "R2", "status after reset", statusOut, 8'h80);
    check({displayOn, cursorOn, blinkOn} == 3'b000, "R2", "display controls after reset",
          {displayOn, cursorOn, blinkOn}, 0);
    check(busWide == 1'b1, "R11", "bus width after reset", busWide, 1);
    check(brightness == 2'd0, "R2", "brightness after reset", brightness, 0);
    check(shiftOfs == '0, "R2", "offset after reset", shiftOfs, 0);
    waitIdle();

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][30:29];
      if (k == KR) busRead(1'b1);
      else         busWrite(k == KW, VEC[i][28:21]);
      waitIdle();
      check(statusOut[6:0] == VEC[i][20:14], "R1 R4 R5 R8 R9",
            $sformatf("vector %0d counter", i), statusOut[6:0], VEC[i][20:14]);
      check(shiftOfs == VEC[i][13:8], "R6 R7",
            $sformatf("vector %0d offset", i), shiftOfs, VEC[i][13:8]);
      if (k == KR) begin
        check(vldSample == 1'b1, "R12", $sformatf("vector %0d rdValid", i), vldSample, 1);
        check(rdSample == VEC[i][7:0], "R12",
              $sformatf("vector %0d read byte", i), rdSample, VEC[i][7:0]);
      end
    end

    // Brightness captured, later capture cancelled, bus width cleared
    check(brightness == 2'd2, "R9", "brightness code", brightness, 2);
    check(busWide == 1'b0, "R11", "narrow bus", busWide, 0);

    // Display control and busy length of a plain command
    busWrite(1'b0, 8'h0D);
    cnt = 0;
    while (statusOut[7]) begin cnt++; @(negedge clk); end
    check(cnt == CMD_CYCLES, "R3", "command busy length", cnt, CMD_CYCLES);
    check({displayOn, cursorOn, blinkOn} == 3'b101, "R11", "display control 0Dh",
          {displayOn, cursorOn, blinkOn}, 3'b101);
    busWrite(1'b0, 8'h3F); waitIdle();
    busWrite(1'b0, 8'h0A); waitIdle();
    check(busWide == 1'b1, "R11", "wide bus", busWide, 1);
    check({displayOn, cursorOn, blinkOn} == 3'b010, "R11", "display control 0Ah",
          {displayOn, cursorOn, blinkOn}, 3'b010);
    check(brightness == 2'd2, "R9", "brightness kept after cancel", brightness, 2);

    // Clear: busy length, counter, offset, forced up-count, S kept
    busWrite(1'b0, 8'h05); waitIdle();
    busWrite(1'b0, 8'h18); waitIdle();
    busWrite(1'b0, 8'h01);
    check(statusOut == 8'h80, "R2", "status right after clear", statusOut, 8'h80);
    check(shiftOfs == '0, "R2", "offset after clear", shiftOfs, 0);
    cnt = 0;
    while (statusOut[7]) begin cnt++; @(negedge clk); end
    check(cnt == CLEAR_CYCLES, "R2", "clear busy length", cnt, CLEAR_CYCLES);
    busWrite(1'b1, 8'h44); waitIdle();
    check(statusOut[6:0] == 7'h01, "R2", "up-count forced by clear", statusOut[6:0], 1);
    check(shiftOfs == SH_W'(1), "R6", "shift-on-write kept by clear", shiftOfs, 1);
    busWrite(1'b0, 8'h80); waitIdle();
    busRead(1'b1); waitIdle();
    check(rdSample == 8'h44, "R12", "read after clear", rdSample, 8'h44);
    busRead(1'b1); waitIdle();
    check(rdSample == 8'h20, "R2", "blank after clear", rdSample, 8'h20);

    // Traffic during busy
    busWrite(1'b0, 8'h01);
    busWrite(1'b0, 8'h85);
    check(statusOut[6:0] == 7'h00, "R3", "address command during busy", statusOut[6:0], 0);
    busWrite(1'b1, 8'h77);
    check(statusOut[6:0] == 7'h00, "R3", "data write during busy", statusOut[6:0], 0);
    busRead(1'b0);
    check(vldSample == 1'b1, "R10", "status read rdValid", vldSample, 1);
    check(rdSample == 8'h80, "R10", "status read byte", rdSample, 8'h80);
    busRead(1'b1);
    check(vldSample == 1'b0, "R3", "data read during busy", vldSample, 0);
    waitIdle();
    check(statusOut == 8'h00, "R10", "status idle", statusOut, 0);
    busWrite(1'b0, 8'h06); waitIdle();
    busRead(1'b1); waitIdle();
    check(rdSample == 8'h20, "R3", "store after ignored write", rdSample, 8'h20);
    check(statusOut[6:0] == 7'h01, "R12", "counter after read", statusOut[6:0], 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule